// File: doc/BRIEF.md
# Low-Power-Domain Reset and Interrupt Controller

This block is a word-addressed register slave that sits in a low-power domain. It holds three kinds of register. An interrupt group has a status bit, a mask bit, and two command registers that unmask or mask that bit, and it drives one level-sensitive interrupt line. A set of reset registers drives hold-in-reset lines to peripherals, to a bank of DMA channels, and to two processor cores. A few clock-control words are kept as plain storage only.

Each core reset bit is owned by a two-state machine with the states `CORE_HELD` and `CORE_RUN`. A write that moves a core from `CORE_RUN` to `CORE_HELD` is a power-off transition and emits a one-cycle off pulse. A write that moves it from `CORE_HELD` to `CORE_RUN` is a restart transition and emits a one-cycle on pulse. A write that leaves the state unchanged is a self-loop and emits nothing. A hardware event input sets the status bit.

Only full-word accesses, with all four byte enables set, take effect. A partial write is dropped and a partial read returns zero. Data is little-endian.

Top module: `lpd_rstirq_ctrl`

## Requirements
- R1: After reset the following values hold. The status reads 0 and the mask reads 1, so `irq` is 0. The core register reads 0x17, `core_rst` is 2'b11, and every `dma_rst` and `periph_rst` line is 1.
- R2: `irq` is high exactly when status bit 0 is 1 and mask bit 0 is 0.
- R3: Status lives at word address 0. `err_evt` sets status bit 0 on the next clock. Writing a 1 to bit 0 clears it, and writing a 0 leaves it alone. If the event and the clearing write arrive in the same cycle, the event wins.
- R4: The mask lives at word address 1 and is read-only, so writes there have no effect.
- R5: A write to word address 2 clears the mask bits wherever the data has ones. This address reads as 0.
- R6: A write to word address 3 sets the mask bits wherever the data has ones. This address reads as 0.
- R7: Peripheral reset k lives at word address 8+k. Its bit 0 drives `periph_rst[k]` and resets to 1, and its other bits read as 0.
- R8: The core register lives at word address 4. Bit 0 controls core 0 and bit 1 controls core 1. Bits 2 and 4 are plain storage, bit 3 is reserved and reads 0, and `core_rst[i]` follows bit i.
- R9: Each core's off and on pulses come from its own state machine. A write that changes core bit i from 0 to 1 pulses `core_off_pulse[i]` high for exactly the one cycle after the write. A change from 1 to 0 does the same on `core_on_pulse[i]`. An unchanged bit gives no pulse.
- R10: Bit 0 of word address 5 drives every `dma_rst` line at once.
- R11: A write whose `bus_be` is not 4'hF changes nothing, and a read with such an enable returns 0.
- R12: Clock word k lives at word address 16+k and resets to 0x0200_0C00. Bits set in 0xFDFC_00F8 are reserved: they ignore writes and read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 6 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte enables; must be all ones |
| bus_rdata | output | 32 | Read data, combinational |
| err_evt | input | 1 | Hardware event that sets status bit 0 |
| irq | output | 1 | Level interrupt |
| core_rst | output | 2 | Per-core hold-in-reset |
| core_off_pulse | output | 2 | One-cycle core power-off event |
| core_on_pulse | output | 2 | One-cycle core restart event |
| dma_rst | output | NUM_DMA | DMA channel resets, all driven from one bit |
| periph_rst | output | NUM_PERIPH | Peripheral resets |

## Verification
The bench targets the following cases:

- **Event and clear in one cycle.** A design that let the clear win would lose the interrupt.
- **Write to the read-only mask.** A design with a write path there would unmask silently.
- **Core register rewrites with an unchanged value.** A level-driven pulse would repeat on every write, and a pulse that is not single-cycle would linger.
- **Both cores released in one write.** This must produce two on pulses together.
- **Reserved bits.** The core register's bit 3 and the reserved clock bits are written with ones. A design that stored them would read them back.
- **Partial-enable accesses.** A design that ignored `bus_be` would unmask, or would change a core.

// File: rtl/lpd_rc_pkg.sv
package lpd_rc_pkg;
    localparam int unsigned ADDR_W = 6;
    localparam int unsigned DATA_W = 32;

    localparam logic [ADDR_W-1:0] A_STAT     = 6'd0;
    localparam logic [ADDR_W-1:0] A_MASK     = 6'd1;
    localparam logic [ADDR_W-1:0] A_UNMASK   = 6'd2;
    localparam logic [ADDR_W-1:0] A_SETMASK  = 6'd3;
    localparam logic [ADDR_W-1:0] A_CORE     = 6'd4;
    localparam logic [ADDR_W-1:0] A_DMA      = 6'd5;
    localparam int unsigned       A_PER_BASE = 8;
    localparam int unsigned       A_CLK_BASE = 16;

    typedef enum logic {
        CORE_RUN  = 1'b0,
        CORE_HELD = 1'b1
    } core_st_e;
endpackage

// File: rtl/lpd_rc_store.sv
module lpd_rc_store #(
    parameter int unsigned W    = 32,
    parameter logic [W-1:0] RST  = '0,
    parameter logic [W-1:0] RSVD = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= RST & ~RSVD;
        else if (we) q <= wdata & ~RSVD;
    end
endmodule

// File: rtl/lpd_rc_irq.sv
module lpd_rc_irq #(
    parameter int unsigned IRQ_W = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IRQ_W-1:0] evt,
    input  logic             clr_we,
    input  logic             unmask_we,
    input  logic             setmask_we,
    input  logic [IRQ_W-1:0] wdata,
    output logic [IRQ_W-1:0] stat_q,
    output logic [IRQ_W-1:0] mask_q,
    output logic             irq
);
    logic [IRQ_W-1:0] clr_bits;
    assign clr_bits = clr_we ? wdata : '0;

    // the event is applied after the clear, so it wins a same-cycle tie
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~clr_bits) | evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          mask_q <= '1;
        else if (unmask_we)  mask_q <= mask_q & ~wdata;
        else if (setmask_we) mask_q <= mask_q | wdata;
    end

    assign irq = |(stat_q & ~mask_q);
endmodule

// File: rtl/lpd_rc_core_fsm.sv
module lpd_rc_core_fsm
    import lpd_rc_pkg::*;
#(
    parameter logic INIT_HELD = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_val,
    output logic held,
    output logic off_pulse,
    output logic on_pulse
);
    core_st_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            unique case (st_q)
                CORE_HELD: if (!wr_val) st_d = CORE_RUN;
                CORE_RUN:  if (wr_val)  st_d = CORE_HELD;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= INIT_HELD ? CORE_HELD : CORE_RUN;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            off_pulse <= 1'b0;
            on_pulse  <= 1'b0;
        end else begin
            off_pulse <= (st_q == CORE_RUN)  && (st_d == CORE_HELD);
            on_pulse  <= (st_q == CORE_HELD) && (st_d == CORE_RUN);
        end
    end

    assign held = (st_q == CORE_HELD);
endmodule

// File: rtl/lpd_rstirq_ctrl.sv
module lpd_rstirq_ctrl
    import lpd_rc_pkg::*;
#(
    parameter int unsigned NUM_PERIPH = 4,
    parameter int unsigned NUM_CLK    = 2,
    parameter int unsigned NUM_DMA    = 8,
    parameter logic [31:0] CLK_RST    = 32'h0200_0C00,
    parameter logic [31:0] CLK_RSVD   = 32'hFDFC_00F8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_sel,
    input  logic                  bus_wr,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    input  logic [3:0]            bus_be,
    output logic [DATA_W-1:0]     bus_rdata,
    input  logic                  err_evt,
    output logic                  irq,
    output logic [1:0]            core_rst,
    output logic [1:0]            core_off_pulse,
    output logic [1:0]            core_on_pulse,
    output logic [NUM_DMA-1:0]    dma_rst,
    output logic [NUM_PERIPH-1:0] periph_rst
);
    localparam int unsigned CORES      = 2;
    localparam logic [31:0] CORE_INIT  = 32'h0000_0017;
    localparam logic [31:0] CORE_SPARE = 32'h0000_0014;

    logic        wr_ok, rd_ok;
    logic [0:0]  stat_q, mask_q;
    logic [31:0] core_spare_q;
    logic [0:0]  dma_q;
    logic [31:0] clk_q [NUM_CLK];

    assign wr_ok = bus_sel &&  bus_wr && (bus_be == 4'hF);
    assign rd_ok = bus_sel && !bus_wr && (bus_be == 4'hF);

    lpd_rc_irq #(.IRQ_W(1)) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt        (err_evt),
        .clr_we     (wr_ok && bus_addr == A_STAT),
        .unmask_we  (wr_ok && bus_addr == A_UNMASK),
        .setmask_we (wr_ok && bus_addr == A_SETMASK),
        .wdata      (bus_wdata[0]),
        .stat_q     (stat_q),
        .mask_q     (mask_q),
        .irq        (irq)
    );

    for (genvar c = 0; c < CORES; c++) begin : g_core
        lpd_rc_core_fsm #(.INIT_HELD(CORE_INIT[c])) u_fsm (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (wr_ok && bus_addr == A_CORE),
            .wr_val    (bus_wdata[c]),
            .held      (core_rst[c]),
            .off_pulse (core_off_pulse[c]),
            .on_pulse  (core_on_pulse[c])
        );
    end

    lpd_rc_store #(.W(32), .RST(CORE_INIT), .RSVD(~CORE_SPARE)) u_core_spare (
        .clk(clk), .rst_n(rst_n), .we(wr_ok && bus_addr == A_CORE),
        .wdata(bus_wdata), .q(core_spare_q)
    );

    lpd_rc_store #(.W(1), .RST(1'b1), .RSVD(1'b0)) u_dma (
        .clk(clk), .rst_n(rst_n), .we(wr_ok && bus_addr == A_DMA),
        .wdata(bus_wdata[0]), .q(dma_q)
    );
    assign dma_rst = {NUM_DMA{dma_q[0]}};

    for (genvar p = 0; p < NUM_PERIPH; p++) begin : g_per
        lpd_rc_store #(.W(1), .RST(1'b1), .RSVD(1'b0)) u_bit (
            .clk(clk), .rst_n(rst_n),
            .we(wr_ok && bus_addr == ADDR_W'(A_PER_BASE + p)),
            .wdata(bus_wdata[0]), .q(periph_rst[p])
        );
    end

    for (genvar k = 0; k < NUM_CLK; k++) begin : g_clk
        lpd_rc_store #(.W(32), .RST(CLK_RST), .RSVD(CLK_RSVD)) u_word (
            .clk(clk), .rst_n(rst_n),
            .we(wr_ok && bus_addr == ADDR_W'(A_CLK_BASE + k)),
            .wdata(bus_wdata), .q(clk_q[k])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (rd_ok) begin
            unique case (bus_addr)
                A_STAT:  bus_rdata = {31'b0, stat_q};
                A_MASK:  bus_rdata = {31'b0, mask_q};
                A_CORE:  bus_rdata = core_spare_q | {30'b0, core_rst};
                A_DMA:   bus_rdata = {31'b0, dma_q};
                default: bus_rdata = '0;
            endcase
            for (int p = 0; p < NUM_PERIPH; p++)
                if (bus_addr == ADDR_W'(A_PER_BASE + p)) bus_rdata = {31'b0, periph_rst[p]};
            for (int k = 0; k < NUM_CLK; k++)
                if (bus_addr == ADDR_W'(A_CLK_BASE + k)) bus_rdata = clk_q[k];
        end
    end
endmodule

// File: rtl/lpd_rc_chk.sv
module lpd_rc_chk
    import lpd_rc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [3:0]        bus_be,
    input logic              err_evt,
    input logic              irq,
    input logic [1:0]        core_rst,
    input logic [1:0]        core_off_pulse,
    input logic [1:0]        core_on_pulse,
    input logic              dma_lo,
    input logic              dma_hi,
    input logic              stat0,
    input logic              mask0
);
    logic full_wr;
    assign full_wr = bus_sel && bus_wr && (bus_be == 4'hF);

    p_evt_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
        err_evt |=> stat0);
    p_w1c_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (full_wr && bus_addr == A_STAT && bus_wdata[0] && !err_evt) |=> !stat0);
    p_mask_ro_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (full_wr && bus_addr == A_MASK) |=> $stable(mask0));
    p_unmask_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (full_wr && bus_addr == A_UNMASK && bus_wdata[0]) |=> !mask0);
    p_setmask_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (full_wr && bus_addr == A_SETMASK && bus_wdata[0]) |=> (mask0 && !irq));
    p_off0_r9: assert property (@(posedge clk) disable iff (!rst_n)
        core_off_pulse[0] == $rose(core_rst[0]));
    p_off1_r9: assert property (@(posedge clk) disable iff (!rst_n)
        core_off_pulse[1] == $rose(core_rst[1]));
    p_on0_r9: assert property (@(posedge clk) disable iff (!rst_n)
        core_on_pulse[0] == $fell(core_rst[0]));
    p_on1_r9: assert property (@(posedge clk) disable iff (!rst_n)
        core_on_pulse[1] == $fell(core_rst[1]));
    p_dma_fan_r10: assert property (@(posedge clk) disable iff (!rst_n)
        dma_lo == dma_hi);
    p_partial_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_be != 4'hF) |=> ($stable(mask0) && $stable(core_rst)));
endmodule

bind lpd_rstirq_ctrl lpd_rc_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .bus_sel        (bus_sel),
    .bus_wr         (bus_wr),
    .bus_addr       (bus_addr),
    .bus_wdata      (bus_wdata),
    .bus_be         (bus_be),
    .err_evt        (err_evt),
    .irq            (irq),
    .core_rst       (core_rst),
    .core_off_pulse (core_off_pulse),
    .core_on_pulse  (core_on_pulse),
    .dma_lo         (dma_rst[0]),
    .dma_hi         (dma_rst[NUM_DMA-1]),
    .stat0          (stat_q[0]),
    .mask0          (mask_q[0])
);

// File: tb/lpd_rstirq_ctrl_tb.sv
`timescale 1ns/1ps
module lpd_rstirq_ctrl_tb;
    typedef enum int {OBS_RD, OBS_IRQ, OBS_CRST, OBS_OFF, OBS_ON, OBS_DMA, OBS_PER} obs_e;
    typedef struct {
        int          cyc;
        obs_e        obs;
        logic [31:0] val;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0, err_evt = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_rdata;
    logic        irq;
    logic [1:0]  core_rst, core_off_pulse, core_on_pulse;
    logic [7:0]  dma_rst;
    logic [3:0]  periph_rst;

    item_t sb[$];
    int    cur_cyc = 0;
    int    checks = 0;
    int    fails = 0;
    bit    done = 1'b0;

    always #2.5 clk = ~clk;

    lpd_rstirq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_be(bus_be),
        .bus_rdata(bus_rdata), .err_evt(err_evt), .irq(irq),
        .core_rst(core_rst), .core_off_pulse(core_off_pulse),
        .core_on_pulse(core_on_pulse), .dma_rst(dma_rst), .periph_rst(periph_rst)
    );

    task automatic op(input logic sel, input logic wr, input logic [5:0] a,
                      input logic [31:0] d, input logic [3:0] be, input logic ev);
        @(negedge clk);
        cur_cyc++;
        bus_sel = sel; bus_wr = wr; bus_addr = a; bus_wdata = d; bus_be = be; err_evt = ev;
    endtask

    task automatic idle(input logic ev = 1'b0);
        op(1'b0, 1'b0, 6'd0, 32'd0, 4'h0, ev);
    endtask
    task automatic wr(input logic [5:0] a, input logic [31:0] d, input logic [3:0] be = 4'hF,
                      input logic ev = 1'b0);
        op(1'b1, 1'b1, a, d, be, ev);
    endtask
    task automatic rd(input logic [5:0] a, input logic [3:0] be = 4'hF);
        op(1'b1, 1'b0, a, 32'd0, be, 1'b0);
    endtask
    task automatic expect_val(input obs_e o, input logic [31:0] v, input string tag);
        item_t it;
        it.cyc = cur_cyc; it.obs = o; it.val = v; it.tag = tag;
        sb.push_back(it);
    endtask

    // monitor: compares everything queued for the current cycle, away from the clock edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb.size() > 0 && sb[0].cyc == cur_cyc) begin
                item_t it;
                logic [31:0] act;
                it = sb.pop_front();
                case (it.obs)
                    OBS_RD:   act = bus_rdata;
                    OBS_IRQ:  act = {31'b0, irq};
                    OBS_CRST: act = {30'b0, core_rst};
                    OBS_OFF:  act = {30'b0, core_off_pulse};
                    OBS_ON:   act = {30'b0, core_on_pulse};
                    OBS_DMA:  act = {24'b0, dma_rst};
                    default:  act = {28'b0, periph_rst};
                endcase
                checks++;
                if (act !== it.val) begin
                    fails++;
                    $display("FAIL %s: actual 0x%08h expected 0x%08h", it.tag, act, it.val);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) idle();
        @(negedge clk); rst_n = 1'b1;

        // R1 reset state
        idle();
        expect_val(OBS_IRQ, 0, "R1 irq");
        expect_val(OBS_CRST, 3, "R1 core_rst");
        expect_val(OBS_DMA, 32'hFF, "R1 dma_rst");
        expect_val(OBS_PER, 32'hF, "R1/R7 periph_rst");
        expect_val(OBS_OFF, 0, "R1 off pulse");
        expect_val(OBS_ON, 0, "R1 on pulse");
        rd(6'd0);  expect_val(OBS_RD, 0, "R1 status");
        rd(6'd1);  expect_val(OBS_RD, 1, "R1 mask");
        rd(6'd4);  expect_val(OBS_RD, 32'h17, "R1 core reg");
        rd(6'd16); expect_val(OBS_RD, 32'h0200_0C00, "R12 clock reset value");

        // R2/R3 event while masked
        idle(1'b1);
        idle(); expect_val(OBS_IRQ, 0, "R2 masked irq");
        rd(6'd0); expect_val(OBS_RD, 1, "R3 event sets status");

        // R4 mask is read-only
        wr(6'd1, 32'h0);
        rd(6'd1); expect_val(OBS_RD, 1, "R4 mask write ignored");

        // R5 unmask
        wr(6'd2, 32'h1);
        idle(); expect_val(OBS_IRQ, 1, "R5/R2 irq after unmask");
        rd(6'd2); expect_val(OBS_RD, 0, "R5 unmask reads zero");
        rd(6'd1); expect_val(OBS_RD, 0, "R5 mask cleared");

        // R3 write-one-to-clear
        wr(6'd0, 32'h0);
        idle(); expect_val(OBS_IRQ, 1, "R3 zero write keeps status");
        wr(6'd0, 32'h1);
        idle(); expect_val(OBS_IRQ, 0, "R3 w1c drops irq");
        rd(6'd0); expect_val(OBS_RD, 0, "R3 status cleared");
        wr(6'd0, 32'h1, 4'hF, 1'b1);
        rd(6'd0); expect_val(OBS_RD, 1, "R3 event beats clear");
        idle(); expect_val(OBS_IRQ, 1, "R2 irq unmasked");

        // R6 set mask
        wr(6'd3, 32'h1);
        idle(); expect_val(OBS_IRQ, 0, "R6 irq masked");
        rd(6'd1); expect_val(OBS_RD, 1, "R6 mask set");
        rd(6'd3); expect_val(OBS_RD, 0, "R6 set-mask reads zero");

        // R11 partial accesses
        wr(6'd2, 32'h1, 4'h3);
        rd(6'd1); expect_val(OBS_RD, 1, "R11 partial unmask ignored");
        idle(); expect_val(OBS_IRQ, 0, "R11 irq still masked");
        rd(6'd1, 4'h3); expect_val(OBS_RD, 0, "R11 partial read zero");
        wr(6'd4, 32'h0, 4'h1);
        idle(); expect_val(OBS_CRST, 3, "R11 partial core write ignored");
        expect_val(OBS_ON, 0, "R11 no pulse");

        // R9/R8 core transitions
        wr(6'd4, 32'h16);
        idle(); expect_val(OBS_ON, 1, "R9 core0 on pulse");
        expect_val(OBS_OFF, 0, "R9 no off pulse");
        expect_val(OBS_CRST, 2, "R8 core0 released");
        idle(); expect_val(OBS_ON, 0, "R9 pulse single cycle");
        wr(6'd4, 32'h16);
        idle(); expect_val(OBS_ON, 0, "R9 unchanged no on");
        expect_val(OBS_OFF, 0, "R9 unchanged no off");
        wr(6'd4, 32'h1F);
        idle(); expect_val(OBS_OFF, 1, "R9 core0 off pulse");
        expect_val(OBS_CRST, 3, "R8 core0 held");
        rd(6'd4); expect_val(OBS_RD, 32'h17, "R8 reserved bit3 reads zero");
        wr(6'd4, 32'h04);
        idle(); expect_val(OBS_ON, 3, "R9 both cores on");
        expect_val(OBS_CRST, 0, "R8 both released");
        rd(6'd4); expect_val(OBS_RD, 32'h04, "R8 spare bits stored");
        wr(6'd4, 32'h02);
        idle(); expect_val(OBS_OFF, 2, "R9 core1 off only");
        expect_val(OBS_ON, 0, "R9 core0 unchanged");

        // R10 DMA fan-out
        wr(6'd5, 32'h0);
        idle(); expect_val(OBS_DMA, 0, "R10 all dma released");
        rd(6'd5); expect_val(OBS_RD, 0, "R10 dma reads zero");
        wr(6'd5, 32'h1);
        idle(); expect_val(OBS_DMA, 32'hFF, "R10 all dma held");

        // R7 peripheral resets
        wr(6'd9, 32'h0);
        idle(); expect_val(OBS_PER, 32'hD, "R7 periph1 released");
        rd(6'd9); expect_val(OBS_RD, 0, "R7 periph1 reads zero");
        wr(6'd10, 32'hFFFF_FFFE);
        idle(); expect_val(OBS_PER, 32'h9, "R7 periph2 released");
        wr(6'd9, 32'hFFFF_FFFF);
        idle(); expect_val(OBS_PER, 32'hB, "R7 periph1 held");
        rd(6'd9); expect_val(OBS_RD, 1, "R7 upper bits read zero");

        // R12 clock storage
        wr(6'd17, 32'hFFFF_FFFF);
        rd(6'd17); expect_val(OBS_RD, 32'h0203_FF07, "R12 reserved bits masked");
        wr(6'd17, 32'h0);
        rd(6'd17); expect_val(OBS_RD, 0, "R12 cleared");

        idle();
        idle();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule